// File: doc/BRIEF.md
# Serial Audio Frame Receiver

This block deserialises a two-channel PCM stream arriving on a serial audio port and hands out one left/right sample pair per frame on a parallel bus qualified by a single-cycle strobe. It runs directly on the bit clock: every rising edge of `clk` samples one data bit (`sd_in`) and the frame-sync level (`fs_in`). Static configuration inputs choose one of five framings: two level-framed MSB-first layouts that differ in polarity and delay (I2S and left-justified), a level-framed layout with LSB-aligned data (right-justified), and two pulse-framed layouts in which one short sync pulse marks the start of a frame and the right slot follows the left slot at once. The configuration also selects the sample width and the slot width, the number of bit clocks per channel slot.

The controller is a four-state machine. `ST_OFF` holds while the configuration is illegal. `ST_HUNT` waits for the first left-slot start. `ST_LEFT` and `ST_RIGHT` shift bits into a slot register and count them. The transitions are: OFF→HUNT when the configuration becomes legal; HUNT→LEFT on a left-slot start; LEFT→RIGHT on a right-slot start (a sync edge in level-framed modes, or the slot count reaching the slot width in pulse-framed modes); RIGHT→LEFT on the next left-slot start, which closes the frame; LEFT→LEFT when a left-slot start arrives too early; and any state→OFF when the configuration turns illegal. Each slot length is measured against the configured slot width when the slot closes. A mismatch drops the frame and sets a sticky error flag. Samples are taken at the chosen width and sign-extended to 24 bits. When mono is selected, the left sample is driven on both outputs.

Top module: `sar_rx`

## Requirements
- R1: The format code `cfg_fmt` selects 0 = I2S, 1 = left-justified, 2 = right-justified, 3 = pulse mode A, 7 = pulse mode B. The width code `cfg_wcode` selects 0 = 16, 1 = 20, 2 = 24 bits. `cfg_slot` is the literal slot length and must be 16, 24 or 32. A format code of 4 to 6, a width code of 3, any other slot value, or a sample width larger than the slot each keep the block idle: no `smp_valid` and no change of `frame_err`.
- R2: I2S: the left slot is the half with `fs_in` low. Its MSB is sampled on the clock after the clock at which `fs_in` is first seen low, and the sample is the first W bits of the slot.
- R3: Left-justified: the left slot is the half with `fs_in` high. Its MSB is sampled on the same clock at which the new `fs_in` level is first seen, and the sample is the first W bits of the slot.
- R4: Right-justified: framing is the same as R3, but the sample is the last W bits of the slot, with its LSB on the final bit clock of the slot. The earlier bits of the slot have no effect on the output.
- R5: Pulse mode A: a rising `fs_in` marks a frame, and the left MSB is sampled one clock after the first clock at which `fs_in` is seen high. Pulse mode B: the left MSB is sampled on that same clock. In both modes the right slot begins right after the last left bit, and the next sync must follow the right slot directly.
- R6: Samples are sign-extended from W bits to 24 bits. With a 32-bit slot and 24-bit width in an MSB-first mode, the top 24 bits are kept and the lower 8 are discarded.
- R7: With `cfg_mono` high, `smp_right` equals `smp_left` and both carry the left slot's sample.
- R8: `smp_valid` is high for one clock per good frame. It rises on the clock after the one that samples the first bit of the next left slot.
- R9: A left or right slot whose length differs from `cfg_slot` sets `frame_err`, which stays set until reset. The affected frame produces no `smp_valid`, and the frames that follow it are delivered normally.
- R10: After reset, `smp_valid`, `frame_err`, `smp_left` and `smp_right` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; data and sync are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 3 | Frame format code (static) |
| cfg_wcode | input | 2 | Sample width code (static) |
| cfg_slot | input | 6 | Bit clocks per channel slot (static) |
| cfg_mono | input | 1 | Copy the left sample to both outputs |
| fs_in | input | 1 | Frame sync level or pulse |
| sd_in | input | 1 | Serial data, MSB first |
| smp_left | output | 24 | Left sample, sign-extended |
| smp_right | output | 24 | Right sample, sign-extended |
| smp_valid | output | 1 | One-clock strobe per delivered frame |
| frame_err | output | 1 | Sticky slot-length error flag |

## Verification
The hardest case to reach is a malformed slot in the middle of a clean stream. The stimulus has to keep the block locked, corrupt exactly one frame, and then show both that this frame is dropped and that the next frames are delivered. The bench does this by repeating a single bit clock, either in the left slot or in the right slot, inside one chosen frame of a burst. It then compares the delivered pairs against a queue that leaves out the corrupted frame. In pulse-framed modes the extra bit can only appear as an over-long right slot, which covers the path where the left/right switch is driven by the counter.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam int SMP_W = 24;
    localparam int SHR_W = 32;
    localparam int CNT_W = 6;

    localparam logic [2:0] FMT_I2S  = 3'd0;
    localparam logic [2:0] FMT_LJ   = 3'd1;
    localparam logic [2:0] FMT_RJ   = 3'd2;
    localparam logic [2:0] FMT_DSPA = 3'd3;
    localparam logic [2:0] FMT_DSPB = 3'd7;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_HUNT,
        ST_LEFT,
        ST_RIGHT
    } rx_state_t;
endpackage

// File: rtl/sar_sync_det.sv
module sar_sync_det
    import sar_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] fmt,
    input  logic       fs_in,
    output logic       evt_left,
    output logic       evt_right
);
    logic fs_q, fs_q2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q  <= 1'b0;
            fs_q2 <= 1'b0;
        end else begin
            fs_q  <= fs_in;
            fs_q2 <= fs_q;
        end
    end

    // Slot-start events: the current clock samples bit 0 of a slot.
    always_comb begin
        evt_left  = 1'b0;
        evt_right = 1'b0;
        case (fmt)
            FMT_I2S: begin
                evt_left  = (fs_q ^ fs_q2) & ~fs_q;
                evt_right = (fs_q ^ fs_q2) &  fs_q;
            end
            FMT_LJ, FMT_RJ: begin
                evt_left  = (fs_in ^ fs_q) &  fs_in;
                evt_right = (fs_in ^ fs_q) & ~fs_in;
            end
            FMT_DSPA: evt_left = fs_q & ~fs_q2;
            FMT_DSPB: evt_left = fs_in & ~fs_q;
            default: begin
                evt_left  = 1'b0;
                evt_right = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sar_shifter.sv
module sar_shifter #(
    parameter int WIDTH = sar_pkg::SHR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic             sd_in,
    output logic [WIDTH-1:0] shreg
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= {{(WIDTH-1){1'b0}}, sd_in};
        end else if (shift) begin
            shreg <= {shreg[WIDTH-2:0], sd_in};
        end
    end
endmodule

// File: rtl/sar_extract.sv
module sar_extract #(
    parameter int IN_W  = sar_pkg::SHR_W,
    parameter int OUT_W = sar_pkg::SMP_W,
    parameter int LEN_W = sar_pkg::CNT_W
) (
    input  logic [IN_W-1:0]  shreg,
    input  logic [LEN_W-1:0] slot,
    input  logic [LEN_W-1:0] wbits,
    input  logic             rjust,
    output logic [OUT_W-1:0] sample
);
    logic [IN_W-1:0]  aligned;
    logic [LEN_W-1:0] shamt;
    logic             sign;

    always_comb begin
        shamt   = slot - wbits;
        aligned = rjust ? shreg : (shreg >> shamt);
        sign    = aligned[wbits - LEN_W'(1)];
        for (int k = 0; k < OUT_W; k++) begin
            sample[k] = (LEN_W'(k) < wbits) ? aligned[k] : sign;
        end
    end
endmodule

// File: rtl/sar_fsm.sv
module sar_fsm
    import sar_pkg::*;
#(
    parameter int OUT_W = SMP_W,
    parameter int LEN_W = CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_ok,
    input  logic             dsp,
    input  logic             mono,
    input  logic [LEN_W-1:0] slot,
    input  logic             evt_left,
    input  logic             evt_right,
    input  logic [OUT_W-1:0] word,
    output logic             load,
    output logic             shift,
    output logic [OUT_W-1:0] smp_left,
    output logic [OUT_W-1:0] smp_right,
    output logic             smp_valid,
    output logic             frame_err
);
    rx_state_t        state, nxt;
    logic [LEN_W-1:0] cnt;
    logic             bad, bad_nxt;
    logic [OUT_W-1:0] hold_left;
    logic             latch_left, emit, err_set, auto_right;

    assign auto_right = dsp && (state == ST_LEFT) && (cnt == slot);

    always_comb begin
        nxt        = state;
        load       = 1'b0;
        shift      = 1'b0;
        latch_left = 1'b0;
        emit       = 1'b0;
        err_set    = 1'b0;
        bad_nxt    = bad;
        if (!cfg_ok) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: nxt = ST_HUNT;
                ST_HUNT: begin
                    if (evt_left) begin
                        nxt     = ST_LEFT;
                        load    = 1'b1;
                        bad_nxt = 1'b0;
                    end
                end
                ST_LEFT: begin
                    if (evt_left) begin
                        err_set = 1'b1;
                        load    = 1'b1;
                        bad_nxt = 1'b0;
                    end else if (evt_right || auto_right) begin
                        latch_left = 1'b1;
                        load       = 1'b1;
                        nxt        = ST_RIGHT;
                        if (cnt != slot) begin
                            err_set = 1'b1;
                            bad_nxt = 1'b1;
                        end
                    end else begin
                        shift = 1'b1;
                    end
                end
                ST_RIGHT: begin
                    if (evt_left) begin
                        load    = 1'b1;
                        nxt     = ST_LEFT;
                        bad_nxt = 1'b0;
                        if (cnt != slot) begin
                            err_set = 1'b1;
                        end else if (!bad) begin
                            emit = 1'b1;
                        end
                    end else begin
                        shift = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            bad       <= 1'b0;
            hold_left <= '0;
            smp_left  <= '0;
            smp_right <= '0;
            smp_valid <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            bad       <= bad_nxt;
            smp_valid <= emit;
            frame_err <= frame_err | err_set;
            if (load) begin
                cnt <= LEN_W'(1);
            end else if (shift && (cnt != '1)) begin
                cnt <= cnt + LEN_W'(1);
            end
            if (latch_left) begin
                hold_left <= word;
            end
            if (emit) begin
                smp_left  <= hold_left;
                smp_right <= mono ? hold_left : word;
            end
        end
    end
endmodule

// File: rtl/sar_rx.sv
module sar_rx
    import sar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_fmt,
    input  logic [1:0]        cfg_wcode,
    input  logic [CNT_W-1:0]  cfg_slot,
    input  logic              cfg_mono,
    input  logic              fs_in,
    input  logic              sd_in,
    output logic [SMP_W-1:0]  smp_left,
    output logic [SMP_W-1:0]  smp_right,
    output logic              smp_valid,
    output logic              frame_err
);
    logic [CNT_W-1:0] wbits;
    logic             fmt_ok, slot_ok, cfg_ok, dsp, rjust;
    logic             evt_left, evt_right, load, shift;
    logic [SHR_W-1:0] shreg;
    logic [SMP_W-1:0] word;

    always_comb begin
        wbits   = CNT_W'(16) + {2'b00, cfg_wcode, 2'b00};
        fmt_ok  = (cfg_fmt == FMT_I2S) || (cfg_fmt == FMT_LJ) || (cfg_fmt == FMT_RJ)
               || (cfg_fmt == FMT_DSPA) || (cfg_fmt == FMT_DSPB);
        slot_ok = (cfg_slot == CNT_W'(16)) || (cfg_slot == CNT_W'(24))
               || (cfg_slot == CNT_W'(32));
        cfg_ok  = fmt_ok && slot_ok && (cfg_wcode != 2'd3) && (wbits <= cfg_slot);
        dsp     = (cfg_fmt == FMT_DSPA) || (cfg_fmt == FMT_DSPB);
        rjust   = (cfg_fmt == FMT_RJ);
    end

    sar_sync_det u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt       (cfg_fmt),
        .fs_in     (fs_in),
        .evt_left  (evt_left),
        .evt_right (evt_right)
    );

    sar_shifter #(.WIDTH(SHR_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .shift (shift),
        .sd_in (sd_in),
        .shreg (shreg)
    );

    sar_extract #(.IN_W(SHR_W), .OUT_W(SMP_W), .LEN_W(CNT_W)) u_ext (
        .shreg  (shreg),
        .slot   (cfg_slot),
        .wbits  (wbits),
        .rjust  (rjust),
        .sample (word)
    );

    sar_fsm #(.OUT_W(SMP_W), .LEN_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_ok    (cfg_ok),
        .dsp       (dsp),
        .mono      (cfg_mono),
        .slot      (cfg_slot),
        .evt_left  (evt_left),
        .evt_right (evt_right),
        .word      (word),
        .load      (load),
        .shift     (shift),
        .smp_left  (smp_left),
        .smp_right (smp_right),
        .smp_valid (smp_valid),
        .frame_err (frame_err)
    );
endmodule

// File: rtl/sar_rx_chk.sv
module sar_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  cfg_fmt,
    input logic [1:0]  cfg_wcode,
    input logic [5:0]  cfg_slot,
    input logic        cfg_mono,
    input logic [23:0] smp_left,
    input logic [23:0] smp_right,
    input logic        smp_valid,
    input logic        frame_err
);
    logic legal;

    always_comb begin
        legal = (cfg_fmt inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd7})
             && (cfg_slot inside {6'd16, 6'd24, 6'd32})
             && (cfg_wcode != 2'd3)
             && ((7'd16 + 7'(cfg_wcode) * 7'd4) <= {1'b0, cfg_slot});
    end

    a_r1_idle_when_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |=> (!smp_valid && $stable(frame_err)));

    a_r6_sext16: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && cfg_wcode == 2'd0) |-> (smp_left[23:16] == {8{smp_left[15]}}));

    a_r6_sext20: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && cfg_wcode == 2'd1) |-> (smp_right[23:20] == {4{smp_right[19]}}));

    a_r7_mono_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && cfg_mono) |-> (smp_left == smp_right));

    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);

    a_r9_err_drops_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> !smp_valid);
endmodule

bind sar_rx sar_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_fmt   (cfg_fmt),
    .cfg_wcode (cfg_wcode),
    .cfg_slot  (cfg_slot),
    .cfg_mono  (cfg_mono),
    .smp_left  (smp_left),
    .smp_right (smp_right),
    .smp_valid (smp_valid),
    .frame_err (frame_err)
);

// File: tb/tb_sar_rx.sv
module tb_sar_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_fmt = 3'd0;
    logic [1:0]  cfg_wcode = 2'd0;
    logic [5:0]  cfg_slot = 6'd16;
    logic        cfg_mono = 1'b0;
    logic        fs_in = 1'b0;
    logic        sd_in = 1'b0;
    logic [23:0] smp_left, smp_right;
    logic        smp_valid, frame_err;

    int n_chk = 0;
    int n_bad = 0;
    int n_got = 0;
    logic [23:0] exp_l[$];
    logic [23:0] exp_r[$];
    string cur_req = "R8";

    always #5 clk = ~clk;

    sar_rx dut (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_wcode(cfg_wcode),
        .cfg_slot(cfg_slot), .cfg_mono(cfg_mono), .fs_in(fs_in), .sd_in(sd_in),
        .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid),
        .frame_err(frame_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic bit fs_at(input logic [2:0] f, input int s, input int i);
        case (f)
            3'd0:       return (((i + 1) % (2 * s)) >= s);
            3'd1, 3'd2: return (i < s);
            3'd3:       return (i == 2 * s - 1);
            default:    return (i == 0);
        endcase
    endfunction

    function automatic logic [23:0] sext(input logic [31:0] v, input int w);
        logic [23:0] r;
        for (int k = 0; k < 24; k++) r[k] = (k < w) ? v[k] : v[w - 1];
        return r;
    endfunction

    function automatic logic [23:0] exp_word(input logic [31:0] bits, input int s,
                                             input int w, input bit rj);
        logic [31:0] m;
        m = (32'd1 << w) - 32'd1;
        return rj ? sext(bits & m, w) : sext((bits >> (s - w)) & m, w);
    endfunction

    function automatic bit legal_cfg(input logic [2:0] f, input int wc, input int s);
        return (f inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd7}) && (wc < 3)
            && (s == 16 || s == 24 || s == 32) && (16 + 4 * wc <= s);
    endfunction

    // Monitor: strobes are compared against the expected queue
    always @(negedge clk) begin
        if (rst_n && smp_valid) begin
            n_got++;
            if (exp_l.size() == 0) begin
                chk(1'b0, "R8", "strobe with no frame expected", 1, 0);
            end else begin
                logic [23:0] el, er;
                el = exp_l.pop_front();
                er = exp_r.pop_front();
                chk(smp_left == el, cur_req, "left sample", smp_left, el);
                chk(smp_right == er, cur_req, "right sample", smp_right, er);
            end
        end
    end

    task automatic drive(input bit f, input bit d);
        @(negedge clk);
        fs_in = f;
        sd_in = d;
    endtask

    task automatic run_burst(input logic [2:0] f, input int wc, input int s, input bit mono,
                             input int nfr, input int bad_fr, input int dup_i,
                             input string req);
        bit lg;
        int w, expn;
        logic [31:0] msk;
        lg = legal_cfg(f, wc, s);
        w = 16 + 4 * wc;
        msk = (s == 32) ? 32'hFFFF_FFFF : ((32'd1 << s) - 32'd1);
        cur_req = req;
        rst_n = 1'b0;
        cfg_fmt = f; cfg_wcode = 2'(wc); cfg_slot = 6'(s); cfg_mono = mono;
        fs_in = 1'b0; sd_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(smp_valid == 1'b0 && frame_err == 1'b0, "R10", "flags in reset",
            {smp_valid, frame_err}, 0);
        chk(smp_left == 24'd0 && smp_right == 24'd0, "R10", "samples in reset",
            smp_left | smp_right, 0);
        exp_l.delete(); exp_r.delete();
        n_got = 0; expn = 0;
        rst_n = 1'b1;
        repeat (4) drive(fs_at(f, s, 2 * s - 2), 1'($urandom));
        drive(fs_at(f, s, 2 * s - 1), 1'($urandom));
        for (int fr = 0; fr < nfr; fr++) begin
            logic [31:0] lw, rw;
            lw = $urandom & msk;
            rw = $urandom & msk;
            if (fr == 0) begin
                lw = 32'd1 << (s - 1);
                rw = ~lw & msk;
            end
            if (lg && fr != bad_fr) begin
                logic [23:0] el;
                el = exp_word(lw, s, w, f == 3'd2);
                exp_l.push_back(el);
                exp_r.push_back(mono ? el : exp_word(rw, s, w, f == 3'd2));
                expn++;
            end
            for (int i = 0; i < 2 * s; i++) begin
                logic [31:0] wd;
                wd = (i < s) ? lw : rw;
                drive(fs_at(f, s, i), wd[s - 1 - (i % s)]);
                if (fr == bad_fr && i == dup_i) drive(fs_at(f, s, i), wd[s - 1 - (i % s)]);
            end
        end
        repeat (4) drive(fs_at(f, s, 0), 1'b0);
        chk(n_got == expn, lg ? "R8" : "R1", "strobes per burst", n_got, expn);
        chk(exp_l.size() == 0, "R8", "undelivered frames", exp_l.size(), 0);
        chk(frame_err == (lg && bad_fr >= 0), "R9", "sticky error flag",
            frame_err, (lg && bad_fr >= 0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog expired: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        // Directed framing checks
        run_burst(3'd0, 2, 32, 1'b0, 5, -1, 0, "R2");   // I2S, 24 in 32 (also R6)
        run_burst(3'd0, 0, 16, 1'b0, 5, -1, 0, "R2");
        run_burst(3'd1, 0, 16, 1'b0, 5, -1, 0, "R3");
        run_burst(3'd1, 2, 24, 1'b0, 5, -1, 0, "R3");
        run_burst(3'd2, 0, 32, 1'b0, 5, -1, 0, "R4");   // 16 LSB-aligned in 32
        run_burst(3'd2, 1, 24, 1'b0, 5, -1, 0, "R4");
        run_burst(3'd3, 2, 24, 1'b0, 5, -1, 0, "R5");
        run_burst(3'd7, 0, 16, 1'b0, 5, -1, 0, "R5");
        run_burst(3'd1, 2, 32, 1'b0, 5, -1, 0, "R6");   // truncation of 32-bit data
        run_burst(3'd1, 1, 32, 1'b1, 5, -1, 0, "R7");
        run_burst(3'd0, 0, 24, 1'b1, 5, -1, 0, "R7");
        // Malformed slots: one repeated bit clock
        run_burst(3'd1, 0, 16, 1'b0, 5, 2, 1, "R9");
        run_burst(3'd3, 2, 32, 1'b0, 5, 1, 32, "R9");
        run_burst(3'd0, 1, 24, 1'b0, 5, 3, 24, "R9");
        run_burst(3'd7, 0, 16, 1'b0, 5, 0, 1, "R9");
        // Illegal configurations keep the block idle
        run_burst(3'd5, 0, 16, 1'b0, 4, -1, 0, "R1");
        run_burst(3'd1, 3, 32, 1'b0, 4, -1, 0, "R1");
        run_burst(3'd1, 0, 20, 1'b0, 4, -1, 0, "R1");
        run_burst(3'd0, 2, 16, 1'b0, 4, -1, 0, "R1");
        // Constrained random legal configurations
        for (int t = 0; t < 12; t++) begin
            logic [2:0] f;
            int s, wc, bf;
            case ($urandom % 5)
                0: f = 3'd0;
                1: f = 3'd1;
                2: f = 3'd2;
                3: f = 3'd3;
                default: f = 3'd7;
            endcase
            s  = 16 + 8 * int'($urandom % 3);
            wc = int'($urandom % 3);
            if (16 + 4 * wc > s) wc = 0;
            bf = ($urandom % 3 == 0) ? int'($urandom % 4) : -1;
            run_burst(f, wc, s, 1'($urandom), 4, bf, (bf >= 0) ? s : 0, "R8");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule